// File: doc/BRIEF.md
# Dual-Channel Cycle-Stealing DMA Controller

This block takes CPU bus cycles for two DMA channels and says, one stepped cycle at a time, what the bus does in that cycle. The page-copy channel moves 256 bytes from a chosen memory page to a sprite attribute memory port. Each byte takes a read cycle followed by a write cycle. The sample-fetch channel halts the CPU and fetches one byte. Both channels add dummy and alignment cycles so that their real reads fall on even-numbered (get) CPU cycles.

The surrounding logic pulses a step strobe once per CPU cycle and gives the parity of the cycle count with it. Start requests carry a page number or the address the CPU was halted on. Read data comes back on a shared bus. In each stepped cycle the block outputs an action code with an address and a data field, a bus-busy flag and one activity flag per channel. A stolen-cycle counter can be read and cleared. Memory, the sprite memory and the CPU are outside the block.

Top module: `cycle_steal_dma`

## Requirements
- R1: The action code is 0 none, 1 dummy read, 2 page read, 3 sprite write, 4 sample fetch. A non-none code appears only in a cycle where step is high. The busy output is high exactly when the code is not none. The address field is zero unless the code is dummy read or page read. The data field is zero unless the code is sprite write.
- R2: While the sample-fetch channel is not idle it owns every stepped cycle. The page-copy channel holds its state and advances only in stepped cycles where the sample channel is idle.
- R3: A sample-fetch start is accepted only while that channel is idle. A start that arrives while the channel is busy is dropped and leaves the channel's sequence and address unchanged.
- R4: Sample-fetch sequence: a dummy read of the halted address, then a second step. On a get (even) cycle that second step issues the fetch. On a put (odd) cycle it does another dummy read of the halted address and the next step issues the fetch. One more stepped cycle follows with no bus action, and the channel then goes idle. The fetch carries address 0.
- R5: A page-copy start latches the page and zeroes the offset. If the start parity is odd it adds one alignment step. The lead-in and the alignment step each output a dummy read of address 0. A start during a copy restarts the copy with the new page.
- R6: After the lead-in the channel alternates a page read at address {page, offset} with a sprite write. The read data is registered at the end of the read cycle, and the following write cycle outputs it.
- R7: The offset rises by one after each write. After the write at offset 255 the channel goes idle, so exactly 256 bytes are copied.
- R8: The counter adds one for each stepped cycle in which either channel is active, including the silent final sample cycle. A take pulse or a page-copy start sets it to zero plus that cycle's increment.
- R9: Reset puts both channels in idle, clears the counter and the alignment flag, and forces the code to none.
- R10: Each activity output is high exactly while its channel is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One pulse per CPU cycle to be scheduled |
| odd_cycle_i | input | 1 | Parity of the CPU cycle count (1 = put cycle) |
| pc_start_i | input | 1 | Page-copy start request |
| pc_page_i | input | 8 | Source page for the page copy |
| sf_start_i | input | 1 | Sample-fetch start request |
| sf_halt_addr_i | input | 16 | Address the CPU was halted on |
| rd_data_i | input | 8 | Read-data bus |
| cnt_take_i | input | 1 | Read-and-clear strobe for the counter |
| act_code_o | output | 3 | Action code for this cycle |
| act_addr_o | output | 16 | Address for the action |
| act_data_o | output | 8 | Data for a sprite write |
| bus_busy_o | output | 1 | High while the action is not none |
| pc_active_o | output | 1 | Page-copy channel is active |
| sf_active_o | output | 1 | Sample-fetch channel is active |
| stolen_cnt_o | output | 16 | Stolen-cycle count |

## Verification
The assertions assume that step and the parity input change only between clock edges. They also assume that read data is valid during the page-read cycle it answers. The stimulus drives every input at the falling edge and holds it through the next rising edge. A small memory model answers each page read combinationally with the low address byte XOR 0xA5. Counts stay well below the counter's width, so wrap and saturation never show in the checks.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [2:0] {
      ACT_NONE    = 3'd0,
      ACT_DUMMY   = 3'd1,
      ACT_PAGE_RD = 3'd2,
      ACT_SPR_WR  = 3'd3,
      ACT_SAMPLE  = 3'd4
   } act_e;

   typedef enum logic [2:0] {
      SF_IDLE, SF_HALT, SF_DUMMY, SF_ALIGN, SF_TAIL
   } sf_st_e;

   typedef enum logic [2:0] {
      PC_IDLE, PC_PEND, PC_ALIGN, PC_READ, PC_WRITE
   } pc_st_e;
endpackage

// File: rtl/dma_sample_chan.sv
module dma_sample_chan
   import dma_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_i,
   input  logic              odd_i,
   output logic              busy_o,
   output act_e              act_o,
   output logic [ADDR_W-1:0] addr_o
);
   sf_st_e            st_q;
   logic [ADDR_W-1:0] halt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SF_IDLE;
         halt_q <= '0;
      end else if (st_q == SF_IDLE) begin
         if (start_i) begin
            st_q   <= SF_HALT;
            halt_q <= addr_i;
         end
      end else if (step_i) begin
         unique case (st_q)
            SF_HALT:  st_q <= SF_DUMMY;
            SF_DUMMY: st_q <= odd_i ? SF_ALIGN : SF_TAIL;
            SF_ALIGN: st_q <= SF_TAIL;
            SF_TAIL:  st_q <= SF_IDLE;
            default:  st_q <= SF_IDLE;
         endcase
      end
   end

   always_comb begin
      act_o  = ACT_NONE;
      addr_o = '0;
      if (step_i) begin
         unique case (st_q)
            SF_HALT: begin
               act_o  = ACT_DUMMY;
               addr_o = halt_q;
            end
            SF_DUMMY: begin
               act_o  = odd_i ? ACT_DUMMY : ACT_SAMPLE;
               addr_o = odd_i ? halt_q : '0;
            end
            SF_ALIGN: act_o = ACT_SAMPLE;
            default:  act_o = ACT_NONE;
         endcase
      end
   end

   assign busy_o = (st_q != SF_IDLE);

   AST_SF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !step_i) |=> ($stable(halt_q) && $stable(st_q))); // R3

   AST_SF_FETCH_THEN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == ACT_SAMPLE) |=> (st_q == SF_TAIL)); // R4
endmodule

// File: rtl/dma_page_chan.sv
module dma_page_chan
   import dma_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int OFS_W  = 8,
   parameter int DATA_W = 8,
   localparam int ADDR_W = PAGE_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              odd_i,
   input  logic              step_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              busy_o,
   output act_e              act_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   localparam logic [OFS_W-1:0] OFS_LAST = '1;

   pc_st_e            st_q;
   logic [PAGE_W-1:0] page_q;
   logic [OFS_W-1:0]  ofs_q;
   logic              align_q;
   logic [DATA_W-1:0] byte_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PC_IDLE;
         page_q  <= '0;
         ofs_q   <= '0;
         align_q <= 1'b0;
         byte_q  <= '0;
      end else if (start_i) begin
         st_q    <= PC_PEND;
         page_q  <= page_i;
         ofs_q   <= '0;
         align_q <= odd_i;
      end else if (step_i) begin
         unique case (st_q)
            PC_PEND:  st_q <= align_q ? PC_ALIGN : PC_READ;
            PC_ALIGN: st_q <= PC_READ;
            PC_READ: begin
               st_q   <= PC_WRITE;
               byte_q <= rd_data_i;
            end
            PC_WRITE: begin
               ofs_q <= ofs_q + 1'b1;
               st_q  <= (ofs_q == OFS_LAST) ? PC_IDLE : PC_READ;
            end
            default: st_q <= PC_IDLE;
         endcase
      end
   end

   always_comb begin
      act_o  = ACT_NONE;
      addr_o = '0;
      data_o = '0;
      if (step_i) begin
         unique case (st_q)
            PC_PEND, PC_ALIGN: act_o = ACT_DUMMY;
            PC_READ: begin
               act_o  = ACT_PAGE_RD;
               addr_o = {page_q, ofs_q};
            end
            PC_WRITE: begin
               act_o  = ACT_SPR_WR;
               data_o = byte_q;
            end
            default: act_o = ACT_NONE;
         endcase
      end
   end

   assign busy_o = (st_q != PC_IDLE);

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !start_i) |=> ($stable(st_q) && $stable(ofs_q))); // R2

   AST_PC_READ_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == ACT_PAGE_RD && !start_i) |=> (st_q == PC_WRITE && byte_q == $past(rd_data_i))); // R6

   AST_PC_WRAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_o == ACT_SPR_WR && ofs_q == OFS_LAST && !start_i) |=> !busy_o); // R7
endmodule

// File: rtl/dma_steal_ctr.sv
module dma_steal_ctr #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] base, nxt;

   assign base = clr_i ? '0 : count_o;

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (inc_i && base != CNT_MAX) ? base + 1'b1 : base;
      end else begin : g_wrap
         assign nxt = inc_i ? base + 1'b1 : base;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) count_o <= '0;
      else        count_o <= nxt;
   end

   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && count_o != CNT_MAX) |=> (count_o == $past(count_o) + 1'b1)); // R8

   AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !inc_i) |=> (count_o == '0)); // R8
endmodule

// File: rtl/cycle_steal_dma.sv
module cycle_steal_dma
   import dma_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int OFS_W        = 8,
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 16,
   parameter bit CNT_SATURATE = 1'b0,
   localparam int PAGE_W      = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              odd_cycle_i,
   input  logic              pc_start_i,
   input  logic [PAGE_W-1:0] pc_page_i,
   input  logic              sf_start_i,
   input  logic [ADDR_W-1:0] sf_halt_addr_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              cnt_take_i,
   output logic [2:0]        act_code_o,
   output logic [ADDR_W-1:0] act_addr_o,
   output logic [DATA_W-1:0] act_data_o,
   output logic              bus_busy_o,
   output logic              pc_active_o,
   output logic              sf_active_o,
   output logic [CNT_W-1:0]  stolen_cnt_o
);
   if (OFS_W < 1 || PAGE_W < 1) begin : g_bad_split
      $error("cycle_steal_dma: ADDR_W must exceed OFS_W, OFS_W >= 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cycle_steal_dma: CNT_W too small");
   end

   logic              sf_busy, pc_busy;
   act_e              sf_act, pc_act;
   logic [ADDR_W-1:0] sf_addr, pc_addr;
   logic [DATA_W-1:0] pc_data;
   logic              sf_step, pc_step;

   assign sf_step = step_i && sf_busy;
   assign pc_step = step_i && !sf_busy;

   dma_sample_chan #(.ADDR_W(ADDR_W)) u_sf (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (sf_start_i),
      .addr_i  (sf_halt_addr_i),
      .step_i  (sf_step),
      .odd_i   (odd_cycle_i),
      .busy_o  (sf_busy),
      .act_o   (sf_act),
      .addr_o  (sf_addr)
   );

   dma_page_chan #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (pc_start_i),
      .page_i    (pc_page_i),
      .odd_i     (odd_cycle_i),
      .step_i    (pc_step),
      .rd_data_i (rd_data_i),
      .busy_o    (pc_busy),
      .act_o     (pc_act),
      .addr_o    (pc_addr),
      .data_o    (pc_data)
   );

   dma_steal_ctr #(.CNT_W(CNT_W), .SATURATE(CNT_SATURATE)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (step_i && (sf_busy || pc_busy)),
      .clr_i   (cnt_take_i || pc_start_i),
      .count_o (stolen_cnt_o)
   );

   always_comb begin
      if (sf_busy) begin
         act_code_o = sf_act;
         act_addr_o = sf_addr;
         act_data_o = '0;
      end else begin
         act_code_o = pc_act;
         act_addr_o = pc_addr;
         act_data_o = pc_data;
      end
   end

   assign bus_busy_o  = (act_code_o != ACT_NONE);
   assign pc_active_o = pc_busy;
   assign sf_active_o = sf_busy;

   AST_SF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && sf_active_o) |-> (act_code_o != ACT_PAGE_RD && act_code_o != ACT_SPR_WR)); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i) |-> (act_code_o == ACT_NONE && !bus_busy_o)); // R1
endmodule

// File: tb/tb_cycle_steal_dma.sv
module tb_cycle_steal_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0, odd_cycle_i = 1'b0;
   logic        pc_start_i = 1'b0, sf_start_i = 1'b0, cnt_take_i = 1'b0;
   logic [7:0]  pc_page_i = '0;
   logic [15:0] sf_halt_addr_i = '0;
   logic [7:0]  rd_data_i;
   logic [2:0]  act_code_o;
   logic [15:0] act_addr_o;
   logic [7:0]  act_data_o;
   logic        bus_busy_o, pc_active_o, sf_active_o;
   logic [15:0] stolen_cnt_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // memory model: each page read returns its low address byte XOR A5
   assign rd_data_i = act_addr_o[7:0] ^ 8'hA5;

   cycle_steal_dma dut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .odd_cycle_i(odd_cycle_i),
      .pc_start_i(pc_start_i), .pc_page_i(pc_page_i), .sf_start_i(sf_start_i),
      .sf_halt_addr_i(sf_halt_addr_i), .rd_data_i(rd_data_i), .cnt_take_i(cnt_take_i),
      .act_code_o(act_code_o), .act_addr_o(act_addr_o), .act_data_o(act_data_o),
      .bus_busy_o(bus_busy_o), .pc_active_o(pc_active_o), .sf_active_o(sf_active_o),
      .stolen_cnt_o(stolen_cnt_o)
   );

   typedef struct packed {
      logic        stp, odd, sfs;
      logic [15:0] sfa;
      logic        pcs;
      logic [7:0]  pg;
      logic        take;
      logic [2:0]  code;
      logic [15:0] addr;
      logic [7:0]  data;
      logic [15:0] cnt;
      logic        esf, epc;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b1,16'hC123,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd0,1'b0,1'b0},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'hC123,8'h00, 16'd0,1'b1,1'b0},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'hC123,8'h00, 16'd1,1'b1,1'b0},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd4,16'h0000,8'h00, 16'd2,1'b1,1'b0},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd3,1'b1,1'b0},
      '{1'b0,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b1, 3'd0,16'h0000,8'h00, 16'd4,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,16'hC123,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd0,1'b0,1'b0},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'hC123,8'h00, 16'd0,1'b1,1'b0},
      '{1'b1,1'b0,1'b1,16'h7777,1'b0,8'h00,1'b0, 3'd4,16'h0000,8'h00, 16'd1,1'b1,1'b0},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd2,1'b1,1'b0},
      '{1'b0,1'b1,1'b0,16'h0000,1'b1,8'h05,1'b0, 3'd0,16'h0000,8'h00, 16'd3,1'b0,1'b0},
      '{1'b0,1'b0,1'b1,16'h4000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd0,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'h4000,8'h00, 16'd0,1'b1,1'b1},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd4,16'h0000,8'h00, 16'd1,1'b1,1'b1},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd2,1'b1,1'b1},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'h0000,8'h00, 16'd3,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd1,16'h0000,8'h00, 16'd4,1'b0,1'b1},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd2,16'h0500,8'h00, 16'd5,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd3,16'h0000,8'hA5, 16'd6,1'b0,1'b1},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd2,16'h0501,8'h00, 16'd7,1'b0,1'b1},
      '{1'b1,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b1, 3'd3,16'h0000,8'hA4, 16'd8,1'b0,1'b1},
      '{1'b1,1'b1,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd2,16'h0502,8'h00, 16'd1,1'b0,1'b1},
      '{1'b0,1'b0,1'b0,16'h0000,1'b0,8'h00,1'b0, 3'd0,16'h0000,8'h00, 16'd2,1'b0,1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic stp, input logic odd, input logic sfs, input logic [15:0] sfa,
                        input logic pcs, input logic [7:0] pg, input logic take);
      step_i = stp; odd_cycle_i = odd; sf_start_i = sfs; sf_halt_addr_i = sfa;
      pc_start_i = pcs; pc_page_i = pg; cnt_take_i = take;
   endtask

   // after inputs settle: check one stepped cycle's action, then pass the edge
   task automatic check_act(input string req, input logic [2:0] code, input logic [15:0] addr,
                            input logic [7:0] data);
      #5;
      chk({req, " code"}, 32'(act_code_o), 32'(code));
      chk({req, " addr"}, 32'(act_addr_o), 32'(addr));
      chk({req, " data"}, 32'(act_data_o), 32'(data));
      chk("R1 busy", 32'(bus_busy_o), 32'(code != 3'd0));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      #5;
      chk("R9 code in reset", 32'(act_code_o), 0);
      chk("R9 count in reset", 32'(stolen_cnt_o), 0);
      chk("R10 flags in reset", 32'({sf_active_o, pc_active_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: R1 R2 R3 R4 R5 R6 R8 R10
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = VECS[i];
         drive(v.stp, v.odd, v.sfs, v.sfa, v.pcs, v.pg, v.take);
         check_act("R4/R5/R6 table", v.code, v.addr, v.data);
         chk("R8 table count", 32'(stolen_cnt_o), 32'(v.cnt));
         chk("R10 sample flag", 32'(sf_active_o), 32'(v.esf));
         chk("R10 page flag", 32'(pc_active_o), 32'(v.epc));
         @(negedge clk);
      end

      // R5 restart mid-copy with a new page, even start -> no alignment step
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, 8'h0A, 1'b0);
      @(negedge clk);
      drive(1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      check_act("R5 restart lead-in", 3'd1, 16'h0000, 8'h00);
      chk("R8 count zeroed by start", 32'(stolen_cnt_o), 0);
      @(negedge clk);
      // R6 R7 full 256-byte copy
      for (int k = 0; k < 256; k++) begin
         drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
         check_act("R6 page read", 3'd2, {8'h0A, 8'(k)}, 8'h00);
         @(negedge clk);
         drive(1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
         check_act("R6 sprite write", 3'd3, 16'h0000, 8'(k) ^ 8'hA5);
         if (k == 255) chk("R7 active on last write", 32'(pc_active_o), 1);
         @(negedge clk);
      end
      drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      check_act("R7 idle after 256", 3'd0, 16'h0000, 8'h00);
      chk("R7 page flag low", 32'(pc_active_o), 0);
      chk("R8 count after copy", 32'(stolen_cnt_o), 513);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b1);
      #5 chk("R8 idle step not counted", 32'(stolen_cnt_o), 513);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      #5 chk("R8 take clears", 32'(stolen_cnt_o), 0);
      @(negedge clk);

      // R9 reset in the middle of activity
      drive(1'b0, 1'b1, 1'b1, 16'h1234, 1'b1, 8'h33, 1'b0);
      @(negedge clk);
      drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      #5;
      chk("R9 sample idle", 32'(sf_active_o), 0);
      chk("R9 page idle", 32'(pc_active_o), 0);
      chk("R9 count cleared", 32'(stolen_cnt_o), 0);
      chk("R9 code none", 32'(act_code_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      check_act("R9 no action after reset", 3'd0, 16'h0000, 8'h00);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 8'h00, 1'b0);
      #5 chk("R9 count stays zero", 32'(stolen_cnt_o), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule